// File: doc/BRIEF.md
# Pipelined Tag RAM with Comparator

This block is a synchronous single-port static memory that also serves as a cache tag store. Every selected non-write cycle reads the word at the registered address. It also compares that word for equality with the contents of a data-input register. The read word and the one-bit match result leave through a shared output stage. Both appear one rising edge after the cycle was registered. A cycle is therefore one of three kinds: a write, a plain read, or a compare. A compare is a read in which the data output enable is held off and the data-input register is loaded with the tag to check.

Address, write data, write enable and both chip enables pass through rising-edge input registers. A separate load enable decides whether the data-input register takes a new value. A write commits the registered data to the registered address on the following edge, with no external pulse. The data output and the match output each have their own enable. These enables act combinationally on the registered output stage. The default depth is 1K words of 18 bits. Setting `ADDR_W` to 16 gives the full 64K-word array.

Top module: `tagram_pipe`

## Requirements
- R1: The chip is selected only when `ce0_n_i` is 0 and `ce1_i` is 1. A deselected cycle writes nothing, and at its output slot `dout_vld_o` and `match_o` are 0.
- R2: A selected cycle with `wr_n_i` at 0 stores the data-input register contents at the address registered in that cycle. A later read of that address returns the stored word.
- R3: The data-input register takes `din_i` only on an edge where `din_ld_i` is 1, whether or not the chip is selected. Otherwise it keeps its previous value.
- R4: A selected read presented before edge N drives the stored word on `dout_o` with `dout_vld_o` at 1 after edge N+1.
- R5: `match_o` is 1 after edge N+1 exactly when the word read in the cycle registered at edge N equals the data-input register as it stood after edge N.
- R6: In the output slot of a selected write cycle, `dout_vld_o` is 0, `dout_o` is 0 and `match_o` is 0.
- R7: While `oe_n_i` is 1, `dout_vld_o` and `dout_o` are 0 in the same cycle. While `moe_n_i` is 1, `match_o` is 0 in the same cycle. Releasing either enable restores the registered value without a clock edge.
- R8: A read or compare of an address in the cycle right after a write to that address sees the newly written word.
- R9: A synchronous active-high `rst` clears the output stage, so that `dout_vld_o`, `dout_o` and `match_o` are 0. Array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Word address |
| din_i | input | DATA_W | Write data or compare tag |
| din_ld_i | input | 1 | Load enable of the data-input register |
| ce0_n_i | input | 1 | Chip enable, active low |
| ce1_i | input | 1 | Chip enable, active high |
| wr_n_i | input | 1 | Write enable, active low |
| oe_n_i | input | 1 | Asynchronous data output enable, active low |
| moe_n_i | input | 1 | Asynchronous match output enable, active low |
| dout_o | output | DATA_W | Read data, 0 when not driven |
| dout_vld_o | output | 1 | 1 when the data bus would be driven, 0 for high impedance |
| match_o | output | 1 | Compare result |

## Verification
The hardest case to reach is a compare issued in the very next cycle after a write to the same address. Here the array read and the write commit fall on the same edge, and only the forwarding path can deliver the new word. The stimulus table places such back-to-back pairs in sequence, both with the tag reloaded and with the tag left in the register. A directed loop then repeats the pair over several addresses and checks the results against a reference array kept in the bench. The asynchronous enables are toggled between two clock edges while a match is held in the output stage.

// File: rtl/tagram_pkg.sv
package tagram_pkg;

  // Control word carried from the input registers to the output stage
  typedef struct packed {
    logic sel;  // chip selected in this cycle
    logic wr;   // selected write
  } tag_ctl_t;

endpackage

// File: rtl/tagram_inreg.sv
module tagram_inreg
  import tagram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              din_ld_i,
  input  logic              ce0_n_i,
  input  logic              ce1_i,
  input  logic              wr_n_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] din_q,
  output tag_ctl_t          ctl_q
);

  logic sel_now;

  assign sel_now = !ce0_n_i && ce1_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      din_q  <= '0;
      ctl_q  <= '0;
    end else begin
      addr_q    <= addr_i;
      ctl_q.sel <= sel_now;
      ctl_q.wr  <= sel_now && !wr_n_i;
      if (din_ld_i) begin
        din_q <= din_i;
      end
    end
  end

endmodule

// File: rtl/tagram_array.sv
module tagram_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] raddr_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] fwd_q;
  logic              fwd_hit_q;
  logic              hazard;

  // Read on the same edge that commits a write to this address
  assign hazard = we_i && (raddr_i == waddr_i);

  // Plain dual-address block RAM: one write port, one synchronous read port
  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
    ram_q <= mem[raddr_i];
  end

  // Forwarding register outside the RAM so inference is unaffected
  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_hit_q <= 1'b0;
      fwd_q     <= '0;
    end else begin
      fwd_hit_q <= hazard;
      fwd_q     <= wdata_i;
    end
  end

  assign rdata_o = fwd_hit_q ? fwd_q : ram_q;

endmodule

// File: rtl/tagram_outstage.sv
module tagram_outstage
  import tagram_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  tag_ctl_t          ctl_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] tag_i,
  input  logic              oe_n_i,
  input  logic              moe_n_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_vld_o,
  output logic              match_o
);

  logic [DATA_W-1:0] eq_bits;
  logic              tag_hit;
  logic              rd_ok;
  logic [DATA_W-1:0] dout_q;
  logic              dval_q;
  logic              match_q;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_cmp
      assign eq_bits[gi] = rdata_i[gi] ~^ tag_i[gi];
    end
  endgenerate

  assign tag_hit = &eq_bits;
  assign rd_ok   = ctl_i.sel && !ctl_i.wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q  <= '0;
      dval_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      dval_q  <= rd_ok;
      match_q <= rd_ok && tag_hit;
      if (rd_ok) begin
        dout_q <= rdata_i;
      end
    end
  end

  // Asynchronous enables act after the output register
  assign dout_vld_o = dval_q && !oe_n_i;
  assign dout_o     = dout_vld_o ? dout_q : '0;
  assign match_o    = match_q && !moe_n_i;

endmodule

// File: rtl/tagram_pipe.sv
module tagram_pipe
  import tagram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              din_ld_i,
  input  logic              ce0_n_i,
  input  logic              ce1_i,
  input  logic              wr_n_i,
  input  logic              oe_n_i,
  input  logic              moe_n_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_vld_o,
  output logic              match_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q;
  logic [DATA_W-1:0] rdata;
  tag_ctl_t          ctl_q;

  tagram_inreg #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_inreg (
    .clk      (clk),
    .rst      (rst),
    .addr_i   (addr_i),
    .din_i    (din_i),
    .din_ld_i (din_ld_i),
    .ce0_n_i  (ce0_n_i),
    .ce1_i    (ce1_i),
    .wr_n_i   (wr_n_i),
    .addr_q   (addr_q),
    .din_q    (din_q),
    .ctl_q    (ctl_q)
  );

  // The read port takes the unregistered address: this equals reading at
  // the registered address and lets the RAM's own register hold the word.
  tagram_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk     (clk),
    .rst     (rst),
    .raddr_i (addr_i),
    .we_i    (ctl_q.wr),
    .waddr_i (addr_q),
    .wdata_i (din_q),
    .rdata_o (rdata)
  );

  tagram_outstage #(
    .DATA_W (DATA_W)
  ) u_out (
    .clk        (clk),
    .rst        (rst),
    .ctl_i      (ctl_q),
    .rdata_i    (rdata),
    .tag_i      (din_q),
    .oe_n_i     (oe_n_i),
    .moe_n_i    (moe_n_i),
    .dout_o     (dout_o),
    .dout_vld_o (dout_vld_o),
    .match_o    (match_o)
  );

endmodule

// File: rtl/tagram_pipe_chk.sv
module tagram_pipe_chk (
  input logic clk,
  input logic rst,
  input logic ce0_n_i,
  input logic ce1_i,
  input logic wr_n_i,
  input logic oe_n_i,
  input logic dout_vld_o,
  input logic match_o
);

  // R6: a selected write leaves its output slot undriven and unmatched
  p_write_blank_r6: assert property (@(posedge clk) disable iff (rst)
    $past(!ce0_n_i && ce1_i && !wr_n_i, 2) |-> (!dout_vld_o && !match_o));

  // R1: a deselected cycle yields nothing at its output slot
  p_desel_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(ce0_n_i || !ce1_i, 2) |-> (!dout_vld_o && !match_o));

  // R5: a match can only come from a selected read two edges back
  p_match_src_r5: assert property (@(posedge clk) disable iff (rst)
    match_o |-> $past(!ce0_n_i && ce1_i && wr_n_i, 2));

  // R4: driven data needs a selected read and the enable held low now
  p_dout_src_r4: assert property (@(posedge clk) disable iff (rst)
    dout_vld_o |-> ($past(!ce0_n_i && ce1_i && wr_n_i, 2) && !oe_n_i));

  // R9: the cycle after reset shows an empty output stage
  p_reset_clear_r9: assert property (@(posedge clk)
    $past(rst) |-> (!dout_vld_o && !match_o));

endmodule

bind tagram_pipe tagram_pipe_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .ce0_n_i    (ce0_n_i),
  .ce1_i      (ce1_i),
  .wr_n_i     (wr_n_i),
  .oe_n_i     (oe_n_i),
  .dout_vld_o (dout_vld_o),
  .match_o    (match_o)
);

// File: tb/tagram_pipe_test.sv
`timescale 1ns/1ps
module tagram_pipe_test;

  localparam int AW = 10;
  localparam int DW = 18;
  localparam int NV = 15;

  typedef struct packed {
    logic          ce0_n;
    logic          ce1;
    logic          wr_n;
    logic          ld;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          ev;
    logic [DW-1:0] ed;
    logic          em;
  } vec_t;

  // Each row: stimulus, then the expected output seen two edges later
  localparam vec_t VT [NV] = '{
    '{1'b0, 1'b1, 1'b0, 1'b1, 10'd5, 18'h12345, 1'b0, 18'h00000, 1'b0}, // write 5
    '{1'b0, 1'b1, 1'b0, 1'b1, 10'd6, 18'h0ABCD, 1'b0, 18'h00000, 1'b0}, // write 6
    '{1'b0, 1'b1, 1'b1, 1'b0, 10'd5, 18'h00000, 1'b1, 18'h12345, 1'b0}, // read 5
    '{1'b0, 1'b1, 1'b1, 1'b1, 10'd6, 18'h0ABCD, 1'b1, 18'h0ABCD, 1'b1}, // compare hit
    '{1'b0, 1'b1, 1'b1, 1'b1, 10'd5, 18'h12344, 1'b1, 18'h12345, 1'b0}, // compare miss
    '{1'b1, 1'b1, 1'b0, 1'b1, 10'd5, 18'h3FFFF, 1'b0, 18'h00000, 1'b0}, // deselected write
    '{1'b0, 1'b1, 1'b1, 1'b0, 10'd5, 18'h00000, 1'b1, 18'h12345, 1'b0}, // 5 untouched
    '{1'b0, 1'b0, 1'b0, 1'b1, 10'd6, 18'h00000, 1'b0, 18'h00000, 1'b0}, // ce1 low write
    '{1'b0, 1'b1, 1'b1, 1'b0, 10'd6, 18'h3FFFF, 1'b1, 18'h0ABCD, 1'b0}, // ld=0 keeps tag 0
    '{1'b0, 1'b1, 1'b0, 1'b1, 10'd7, 18'h2AAAA, 1'b0, 18'h00000, 1'b0}, // write 7
    '{1'b0, 1'b1, 1'b1, 1'b0, 10'd7, 18'h00000, 1'b1, 18'h2AAAA, 1'b1}, // compare right after
    '{1'b0, 1'b1, 1'b0, 1'b1, 10'd7, 18'h15555, 1'b0, 18'h00000, 1'b0}, // rewrite 7
    '{1'b0, 1'b1, 1'b1, 1'b1, 10'd7, 18'h15555, 1'b1, 18'h15555, 1'b1}, // compare right after
    '{1'b0, 1'b1, 1'b1, 1'b0, 10'd6, 18'h00000, 1'b1, 18'h0ABCD, 1'b0}, // read 6
    '{1'b1, 1'b0, 1'b1, 1'b0, 10'd0, 18'h00000, 1'b0, 18'h00000, 1'b0}  // idle
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] din_i = '0;
  logic          din_ld_i = 1'b0;
  logic          ce0_n_i = 1'b1;
  logic          ce1_i = 1'b0;
  logic          wr_n_i = 1'b1;
  logic          oe_n_i = 1'b0;
  logic          moe_n_i = 1'b0;
  logic [DW-1:0] dout_o;
  logic          dout_vld_o;
  logic          match_o;

  int nchk  = 0;
  int nfail = 0;
  logic [DW-1:0] ref_mem [1 << AW];

  always #2.5 clk = ~clk;

  tagram_pipe #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .addr_i(addr_i), .din_i(din_i), .din_ld_i(din_ld_i),
    .ce0_n_i(ce0_n_i), .ce1_i(ce1_i), .wr_n_i(wr_n_i), .oe_n_i(oe_n_i),
    .moe_n_i(moe_n_i), .dout_o(dout_o), .dout_vld_o(dout_vld_o), .match_o(match_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic c0n, input logic c1, input logic wn, input logic ld,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    ce0_n_i = c0n; ce1_i = c1; wr_n_i = wn; din_ld_i = ld; addr_i = a; din_i = d;
  endtask

  task automatic idle();
    apply(1'b1, 1'b0, 1'b1, 1'b0, '0, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk + 1 - nfail, nchk + 1);
    $finish;
  end

  initial begin
    // R9: reset state
    idle();
    repeat (3) @(negedge clk);
    chk("R9 reset vld", 32'(dout_vld_o), 32'd0);
    chk("R9 reset match", 32'(match_o), 32'd0);
    chk("R9 reset dout", 32'(dout_o), 32'd0);
    rst = 1'b0;

    // Table walk: row k is checked while row k+2 is driven
    for (int k = 0; k < NV + 2; k++) begin
      if (k >= 2) begin
        chk($sformatf("R1 R2 R3 R4 R6 R8 vld row %0d", k - 2), 32'(dout_vld_o), 32'(VT[k-2].ev));
        chk($sformatf("R4 R6 dout row %0d", k - 2), 32'(dout_o), 32'(VT[k-2].ed));
        chk($sformatf("R5 R3 R8 match row %0d", k - 2), 32'(match_o), 32'(VT[k-2].em));
      end
      if (k < NV) apply(VT[k].ce0_n, VT[k].ce1, VT[k].wr_n, VT[k].ld, VT[k].a, VT[k].d);
      else idle();
      @(negedge clk);
    end

    // R7: asynchronous enables between edges
    apply(1'b0, 1'b1, 1'b1, 1'b1, 10'd6, 18'h0ABCD);
    @(negedge clk); idle();
    @(negedge clk);
    chk("R7 held vld", 32'(dout_vld_o), 32'd1);
    chk("R7 held match", 32'(match_o), 32'd1);
    oe_n_i = 1'b1; #0.4;
    chk("R7 oe off vld", 32'(dout_vld_o), 32'd0);
    chk("R7 oe off dout", 32'(dout_o), 32'd0);
    chk("R7 oe off match kept", 32'(match_o), 32'd1);
    moe_n_i = 1'b1; #0.4;
    chk("R7 moe off match", 32'(match_o), 32'd0);
    oe_n_i = 1'b0; moe_n_i = 1'b0; #0.4;
    chk("R7 restore dout", 32'(dout_o), 32'h0ABCD);
    chk("R7 restore match", 32'(match_o), 32'd1);
    @(negedge clk);

    // R8: back-to-back write then compare, against a reference array
    for (int i = 0; i < 6; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = AW'(20 + i);
      d = DW'(32'h2F00F + i * 32'h1357);
      apply(1'b0, 1'b1, 1'b0, 1'b1, a, d);
      ref_mem[a] = d;
      @(negedge clk);
      apply(1'b0, 1'b1, 1'b1, 1'b0, a, '0);
      @(negedge clk); idle();
      @(negedge clk);
      chk($sformatf("R8 raw dout addr %0d", a), 32'(dout_o), 32'(ref_mem[a]));
      chk($sformatf("R8 raw match addr %0d", a), 32'(match_o), 32'd1);
    end

    // R9: reset clears an in-flight read but keeps the array
    apply(1'b0, 1'b1, 1'b1, 1'b0, 10'd5, '0);
    @(negedge clk); idle(); rst = 1'b1;
    @(negedge clk);
    chk("R9 reset flushes read", 32'(dout_vld_o), 32'd0);
    @(negedge clk); rst = 1'b0;
    apply(1'b0, 1'b1, 1'b1, 1'b0, 10'd5, '0);
    @(negedge clk); idle();
    @(negedge clk);
    chk("R9 contents kept", 32'(dout_o), 32'h12345);
    chk("R9 R4 vld after reset", 32'(dout_vld_o), 32'd1);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule